// File: doc/BRIEF.md
# Call-Return Orchestration Controller

This block is a sequencing controller. One supervising state machine hands work to three subordinate worker machines through a call-and-return handshake. The supervisor raises a launch strobe to call a worker. The worker answers with a busy flag for as long as it is occupied. When the flag drops, the call has returned.

A pulse on `tick` begins one processing round. Workers A and B are called together. Worker C is called only after both A and B have returned. Ticks that arrive while a round is in progress have no effect. Each worker models latency only: it steps through a parameterised number of work steps and then goes back to idle.

Two measures keep the handshake safe:
- The supervisor waits in two phases for every call. It first waits to see busy rise, then waits for it to fall.
- Each worker drops busy during its final work step, one cycle before it is idle again. This saves one cycle per call without letting the supervisor miss the call.

Top module: `callret_orchestrator`

## Requirements
- R1: A synchronous active-high `rst` puts the supervisor in idle (code 0) on the next clock. In that cycle all three launch outputs and all three busy outputs are low.
- R2: The supervisor state is reported on `phase_o` with these codes: 0 idle, 1 launch A and B, 2 wait for A and B, 3 launch C, 4 wait for C. A `tick` sampled in idle moves it to code 1. `start_a_o` and `start_b_o` are both high exactly while the code is 1.
- R3: Code 1 is held until `busy_a_o` and `busy_b_o` are both seen high. The state then moves to code 2.
- R4: Code 2 is held while either A or B is busy. It moves to code 3 once both are low. `start_c_o` is never high while `busy_a_o` or `busy_b_o` is high.
- R5: At code 3, `start_c_o` is high until `busy_c_o` is seen high, and the state then moves to code 4. At code 4, the state returns to idle once `busy_c_o` is low.
- R6: A `tick` sampled at any code other than 0 has no effect and does not start an extra round.
- R7: A worker is idle until it samples its launch strobe. Busy goes high on the next cycle and stays high for LEN-1 cycles. Busy is low during the final work step, and the worker is idle again on the following cycle. A launch strobe seen while the worker is working is ignored.
- R8: The work lengths default to A=3, B=5, C=3, and each must be at least 2. A round lasts max(LEN_A, LEN_B) + LEN_C + 2 cycles, counted from the first code-1 cycle to the return to code 0. With the defaults this is 10 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Round trigger, sampled in idle only |
| phase_o | output | 3 | Supervisor state code |
| start_a_o | output | 1 | Launch strobe to worker A |
| start_b_o | output | 1 | Launch strobe to worker B |
| start_c_o | output | 1 | Launch strobe to worker C |
| busy_a_o | output | 1 | Worker A busy |
| busy_b_o | output | 1 | Worker B busy |
| busy_c_o | output | 1 | Worker C busy |

## Verification
The hardest cases to reach from the ports involve timing relative to a round. One is a tick that arrives in the very cycle the supervisor gets back to idle, which must start a new round with no gap. Another is a reset that lands in the middle of a round while the workers are part-way through their steps. A third is a tick that falls inside each of the four busy states.

The stimulus reaches these cases in three ways:
- It holds `tick` high across several rounds, so that rounds run back to back.
- It applies a directed reset during the wait for A and B.
- It then runs a long stretch of seeded random ticks and sparse random resets, which spreads ticks over every offset within a round.

// File: rtl/callret_pkg.sv
package callret_pkg;
   typedef enum logic [2:0] {
      PH_IDLE     = 3'd0,
      PH_LAUNCH_AB = 3'd1,
      PH_WAIT_AB  = 3'd2,
      PH_LAUNCH_C = 3'd3,
      PH_WAIT_C   = 3'd4
   } phase_e;

   localparam int unsigned NUM_WORKERS = 3;
   localparam int unsigned IDX_A = 0;
   localparam int unsigned IDX_B = 1;
   localparam int unsigned IDX_C = 2;
endpackage

// File: rtl/callret_worker.sv
module callret_worker #(
   parameter int unsigned LEN = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic launch_i,
   output logic busy_o
);
   localparam int unsigned SW = $clog2(LEN + 1);
   localparam logic [SW-1:0] LAST = SW'(LEN);

   generate
      if (LEN < 2) begin : g_len_bad
         $error("callret_worker: LEN must be at least 2");
      end
   endgenerate

   logic [SW-1:0] step_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
      end else if (step_q == '0) begin
         if (launch_i) step_q <= SW'(1);
      end else if (step_q == LAST) begin
         step_q <= '0;
      end else begin
         step_q <= step_q + SW'(1);
      end
   end

   assign busy_o = (step_q != '0) && (step_q != LAST);

   p_busy_after_launch_r7 : assert property (@(posedge clk) disable iff (rst)
      (step_q == '0 && launch_i) |=> busy_o);
   p_return_idle_r7 : assert property (@(posedge clk) disable iff (rst)
      (step_q == LAST) |=> (step_q == '0));
   p_no_relaunch_r7 : assert property (@(posedge clk) disable iff (rst)
      (step_q != '0 && step_q != LAST) |=> (step_q == $past(step_q) + SW'(1)));
endmodule

// File: rtl/callret_major.sv
module callret_major
   import callret_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   tick,
   input  logic [NUM_WORKERS-1:0] busy_i,
   output logic [NUM_WORKERS-1:0] launch_o,
   output phase_e                 phase_o
);
   phase_e ph_q, ph_d;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:      if (tick) ph_d = PH_LAUNCH_AB;
         PH_LAUNCH_AB: if (busy_i[IDX_A] && busy_i[IDX_B]) ph_d = PH_WAIT_AB;
         PH_WAIT_AB:   if (!busy_i[IDX_A] && !busy_i[IDX_B]) ph_d = PH_LAUNCH_C;
         PH_LAUNCH_C:  if (busy_i[IDX_C]) ph_d = PH_WAIT_C;
         PH_WAIT_C:    if (!busy_i[IDX_C]) ph_d = PH_IDLE;
         default:      ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ph_q <= PH_IDLE;
      else     ph_q <= ph_d;
   end

   always_comb begin
      launch_o        = '0;
      launch_o[IDX_A] = (ph_q == PH_LAUNCH_AB);
      launch_o[IDX_B] = (ph_q == PH_LAUNCH_AB);
      launch_o[IDX_C] = (ph_q == PH_LAUNCH_C);
   end

   assign phase_o = ph_q;

   p_reset_idle_r1 : assert property (@(posedge clk)
      rst |=> (ph_q == PH_IDLE));
   p_tick_launch_r2 : assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_IDLE && tick) |=> (ph_q == PH_LAUNCH_AB));
   p_hold_launch_r3 : assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_LAUNCH_AB && !(busy_i[IDX_A] && busy_i[IDX_B])) |=> (ph_q == PH_LAUNCH_AB));
   p_hold_wait_ab_r4 : assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_WAIT_AB && (busy_i[IDX_A] || busy_i[IDX_B])) |=> (ph_q == PH_WAIT_AB));
   p_wait_c_done_r5 : assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_WAIT_C && !busy_i[IDX_C]) |=> (ph_q == PH_IDLE));
   p_tick_ignored_r6 : assert property (@(posedge clk) disable iff (rst)
      (ph_q != PH_IDLE) |=> (ph_q != PH_LAUNCH_AB || $past(ph_q) == PH_LAUNCH_AB));
endmodule

// File: rtl/callret_orchestrator.sv
module callret_orchestrator
   import callret_pkg::*;
#(
   parameter int unsigned LEN_A = 3,
   parameter int unsigned LEN_B = 5,
   parameter int unsigned LEN_C = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   output logic [2:0] phase_o,
   output logic       start_a_o,
   output logic       start_b_o,
   output logic       start_c_o,
   output logic       busy_a_o,
   output logic       busy_b_o,
   output logic       busy_c_o
);
   function automatic int unsigned len_of(input int unsigned idx);
      case (idx)
         IDX_A:   return LEN_A;
         IDX_B:   return LEN_B;
         default: return LEN_C;
      endcase
   endfunction

   logic [NUM_WORKERS-1:0] launch;
   logic [NUM_WORKERS-1:0] busy;
   phase_e                 phase;

   callret_major u_major (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .busy_i   (busy),
      .launch_o (launch),
      .phase_o  (phase)
   );

   generate
      for (genvar i = 0; i < NUM_WORKERS; i++) begin : g_worker
         callret_worker #(.LEN(len_of(i))) u_worker (
            .clk      (clk),
            .rst      (rst),
            .launch_i (launch[i]),
            .busy_o   (busy[i])
         );
      end
   endgenerate

   assign phase_o   = phase;
   assign start_a_o = launch[IDX_A];
   assign start_b_o = launch[IDX_B];
   assign start_c_o = launch[IDX_C];
   assign busy_a_o  = busy[IDX_A];
   assign busy_b_o  = busy[IDX_B];
   assign busy_c_o  = busy[IDX_C];

   p_c_after_ab_r4 : assert property (@(posedge clk) disable iff (rst)
      start_c_o |-> (!busy_a_o && !busy_b_o));
   p_reset_quiet_r1 : assert property (@(posedge clk)
      rst |=> (launch == '0 && busy == '0));
endmodule

// File: tb/callret_orchestrator_test.sv
module callret_orchestrator_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LA   = 3;
   localparam int LB   = 5;
   localparam int LC   = 3;
   localparam int MAXL = (LA > LB) ? LA : LB;
   localparam int ROUND = MAXL + LC + 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic [2:0] phase_o;
   logic start_a_o, start_b_o, start_c_o, busy_a_o, busy_b_o, busy_c_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   bit in_round = 1'b0;
   int n = 0;
   bit prev_rst = 1'b1;
   bit tick_in_round = 1'b0;

   always #4 clk = ~clk;

   callret_orchestrator #(.LEN_A(LA), .LEN_B(LB), .LEN_C(LC)) uut (
      .clk(clk), .rst(rst), .tick(tick), .phase_o(phase_o),
      .start_a_o(start_a_o), .start_b_o(start_b_o), .start_c_o(start_c_o),
      .busy_a_o(busy_a_o), .busy_b_o(busy_b_o), .busy_c_o(busy_c_o));

   function automatic logic [2:0] exp_phase(input bit r, input int k);
      if (!r) return 3'd0;
      if (k < 2) return 3'd1;
      if (k < MAXL + 1) return 3'd2;
      if (k < MAXL + 3) return 3'd3;
      return 3'd4;
   endfunction

   function automatic logic [2:0] exp_busy(input bit r, input int k);
      logic [2:0] v;
      v = 3'b000;
      if (r) begin
         v[2] = (k >= 1 && k <= LA - 1);
         v[1] = (k >= 1 && k <= LB - 1);
         v[0] = (k >= MAXL + 2 && k <= MAXL + LC);
      end
      return v;
   endfunction

   function automatic string phase_tag(input logic [2:0] p);
      case (p)
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3, 3'd4: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp, input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (round step %0d)", tag, what, got, exp, n);
      end
   endtask

   task automatic check_cycle();
      logic [2:0] ep, eb, es;
      string tg;
      ep = exp_phase(in_round, n);
      eb = exp_busy(in_round, n);
      es = {ep == 3'd1, ep == 3'd1, ep == 3'd3};
      if (prev_rst) tg = "R1";
      else if (tick_in_round && in_round) tg = "R6";
      else if (in_round && n == 0) tg = "R2";
      else tg = phase_tag(ep);
      check(tg, {5'd0, phase_o}, {5'd0, ep}, "phase");
      check(prev_rst ? "R1" : (ep == 3'd3 ? "R5" : "R2"),
            {5'd0, start_a_o, start_b_o, start_c_o}, {5'd0, es}, "starts");
      check(prev_rst ? "R1" : "R7", {5'd0, busy_a_o, busy_b_o, busy_c_o}, {5'd0, eb}, "busy");
      check("R4", {7'd0, start_c_o & (busy_a_o | busy_b_o)}, 8'd0, "start C with A or B busy");
   endtask

   task automatic step(input logic t, input logic r);
      @(negedge clk);
      check_cycle();
      tick = t;
      rst = r;
      prev_rst = r;
      if (r) begin
         in_round = 1'b0;
         n = 0;
         tick_in_round = 1'b0;
      end else if (in_round) begin
         if (t) tick_in_round = 1'b1;
         if (n + 1 == ROUND) begin
            in_round = 1'b0;
            n = 0;
            tick_in_round = 1'b0;
         end else begin
            n++;
         end
      end else if (t) begin
         in_round = 1'b1;
         n = 0;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(posedge clk);
      // R1: reset state
      step(1'b0, 1'b0);
      // R2 R8: one isolated round
      step(1'b1, 1'b0);
      repeat (ROUND + 4) step(1'b0, 1'b0);
      // R6: tick held high, rounds back to back
      repeat (4 * ROUND) step(1'b1, 1'b0);
      repeat (ROUND) step(1'b0, 1'b0);
      // R1: reset during the wait for A and B
      step(1'b1, 1'b0);
      repeat (3) step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      repeat (8) step(1'b0, 1'b0);
      // R6: tick pulse at every offset within a round
      for (int off = 0; off < ROUND; off++) begin
         step(1'b1, 1'b0);
         for (int j = 0; j < ROUND + 2; j++) step(j == off, 1'b0);
         repeat (ROUND) step(1'b0, 1'b0);
      end
      // random stretch
      for (int i = 0; i < 3000; i++)
         step(($urandom % 5) == 0, ($urandom % 97) == 0);
      step(1'b0, 1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule